// File: doc/BRIEF.md
# Dual-Port MDIO Management Slave

This block is a serial management slave that answers on two adjacent station addresses of one shared MDC/MDIO bus. It runs entirely in the MDC clock domain. It decodes each frame as it arrives: a preamble, a start pattern, an operation code, a station address and a register index. Four of the five station-address bits are compared with a strapped address input. The lowest bit of the frame address chooses one of two channel register banks. A single instance therefore occupies a pair of addresses, and sixteen instances with distinct straps can share one bus.

On a read, the slave fetches a word from the chosen bank and shifts it out through a registered data bit and an output-enable. It does this while respecting the turnaround slot. On a write, it collects sixteen data bits and gives the chosen bank one write strobe. Each bank sees a simple register-file port: a shared register index, shared write data, its own write strobe and its own read-data input. What the banks hold is outside this block. Reads and writes do not depend on any power state of the channels.

Top module: `mdio_dual_slave`

## Requirements
- R1: A frame is served only when frame address bits 4:1 equal `strap_addr[4:1]`; otherwise `mdio_oe` stays low and neither write strobe pulses.
- R2: `strap_addr[0]` has no effect: flipping it leaves reads and writes unchanged.
- R3: Frame address bit 0 selects the bank: 0 selects bank A (`chan_a_*`) and 1 selects bank B (`chan_b_*`). At most one write strobe is high in any cycle.
- R4: The start bits are honoured only after at least 32 consecutive ones. A frame preceded by 31 or fewer ones is ignored.
- R5: After start bits `01`, opcode `10` is a read and `01` is a write. Opcodes `00` and `11` cause the frame to be ignored, with no drive and no strobe.
- R6: Read timing. The bits are sampled on rising MDC. The slave keeps `mdio_oe` low during the first turnaround bit and drives 0 during the second. It then drives the 16 data bits MSB first. Outputs change only at rising MDC, so each bit is stable for a full period. `mdio_oe` drops at the rising edge that ends the last data bit.
- R7: Write timing. The turnaround bits are ignored and 16 data bits are taken MSB first. In the cycle after the edge that samples the last bit, exactly one one-cycle strobe goes to the selected bank, with `reg_wdata` and `reg_addr` valid.
- R8: After an address mismatch, the slave abandons the frame. It serves the next frame only after a fresh preamble.
- R9: `mdio_oe` is low whenever `rst_n` is low, including the cycle in which reset is raised during a read. After reset, the slave waits for a preamble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mdc | input | 1 | Management clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset; also gates `mdio_oe` directly |
| mdio_i | input | 1 | Sampled value of the shared data line |
| mdio_o | output | 1 | Value driven onto the data line when enabled |
| mdio_oe | output | 1 | Tri-state enable for the data line driver |
| strap_addr | input | 5 | Strapped station address; bit 0 is ignored |
| reg_addr | output | 5 | Register index of the frame being served |
| reg_wdata | output | 16 | Write data, valid with a write strobe |
| chan_a_rdata | input | 16 | Read data from bank A for `reg_addr` |
| chan_a_wr | output | 1 | One-cycle write strobe to bank A |
| chan_b_rdata | input | 16 | Read data from bank B for `reg_addr` |
| chan_b_wr | output | 1 | One-cycle write strobe to bank B |

## Verification
The bench targets several boundaries. A preamble one bit short would be accepted by a design that counts to 31. A strap differing only in bit 0 would be refused by a design that compares all five bits. The choice between banks would come out mirrored if the bank-select bit were inverted. Read-frame timing is checked every cycle: a slave that drives during the first turnaround bit, or shifts the data one slot early or late, fails on the exact cycle where it goes wrong. Illegal opcodes, mismatched frames and short preambles are followed by reads that show the banks untouched. A reset raised in the middle of a read must release the line at once rather than on the next edge.

// File: rtl/mdio_dual_pkg.sv
`timescale 1ns/1ps
// Shared types and constants for the dual-port management slave.
// Assumes nothing beyond a single MDC clock domain.
package mdio_dual_pkg;
    // Frame decoder states, in frame order.
    typedef enum logic [2:0] {
        S_PRE,   // counting preamble ones
        S_ST1,   // expecting second start bit
        S_HDR,   // shifting opcode, station and register fields
        S_TA1,   // first turnaround bit
        S_TA2,   // second turnaround bit
        S_DATA   // sixteen data bits
    } frame_state_e;

    localparam logic [1:0] OP_RD = 2'b10;
    localparam logic [1:0] OP_WR = 2'b01;
endpackage

// File: rtl/mdio_port_match.sv
`timescale 1ns/1ps
// Station-address comparator.
// Compares every address bit except the lowest against the strap and
// reports which bank the lowest bit selects. Purely combinational.
module mdio_port_match #(
    parameter int PHY_W = 5
) (
    input  logic [PHY_W-1:0] phy_addr,
    input  logic [PHY_W-1:0] strap,
    output logic             hit,
    output logic             chan_b
);
    localparam logic [PHY_W-1:0] CMP_MASK = {{(PHY_W-1){1'b1}}, 1'b0};

    // Masked equality: the lowest bit only steers the bank.
    always_comb begin
        hit    = ((phy_addr ^ strap) & CMP_MASK) == '0;
        chan_b = phy_addr[0];
    end
endmodule

// File: rtl/mdio_frame_fsm.sv
`timescale 1ns/1ps
// Frame decoder for the management slave.
// Counts preamble ones, checks start and opcode bits, shifts in the
// header and sequences the turnaround and data slots. Assumes mdio_i
// is already synchronous to clk (MDC). Uses an external matcher.
module mdio_frame_fsm
    import mdio_dual_pkg::*;
#(
    parameter int PRE_LEN = 32,
    parameter int PHY_W   = 5,
    parameter int REG_W   = 5,
    parameter int DATA_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mdio_i,
    input  logic              hit,
    input  logic              chan_b_in,
    output frame_state_e      state,
    output logic [PHY_W-1:0]  phy_next,
    output logic [REG_W-1:0]  reg_addr,
    output logic              is_rd,
    output logic              chan,
    output logic              data_last
);
    localparam int HDR_W   = 2 + PHY_W + REG_W;
    localparam int CNT_MAX = (HDR_W > DATA_W) ? HDR_W : DATA_W;
    localparam int CNT_W   = $clog2(CNT_MAX);
    localparam int PRE_CW  = $clog2(PRE_LEN + 1);

    logic [PRE_CW-1:0] pre_cnt;
    logic [CNT_W-1:0]  bit_cnt;
    logic [HDR_W-1:0]  hdr_r;
    logic [HDR_W-1:0]  hdr_nx;
    logic              hdr_last;
    logic              op_chk;
    logic              op_ok;

    // Header shift value including the bit on the line this cycle.
    always_comb begin
        hdr_nx    = {hdr_r[HDR_W-2:0], mdio_i};
        phy_next  = hdr_nx[REG_W +: PHY_W];
        hdr_last  = (state == S_HDR) && (bit_cnt == CNT_W'(HDR_W - 1));
        op_chk    = (state == S_HDR) && (bit_cnt == CNT_W'(1));
        op_ok     = (hdr_nx[1:0] == OP_RD) || (hdr_nx[1:0] == OP_WR);
        data_last = (state == S_DATA) && (bit_cnt == CNT_W'(DATA_W - 1));
    end

    // Frame sequencing, one MDIO bit per rising MDC edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_PRE;
            pre_cnt  <= '0;
            bit_cnt  <= '0;
            hdr_r    <= '0;
            reg_addr <= '0;
            is_rd    <= 1'b0;
            chan     <= 1'b0;
        end else begin
            case (state)
                S_PRE: begin
                    if (mdio_i) begin
                        if (pre_cnt != PRE_CW'(PRE_LEN))
                            pre_cnt <= pre_cnt + 1'b1;
                    end else if (pre_cnt == PRE_CW'(PRE_LEN)) begin
                        state   <= S_ST1;
                        pre_cnt <= '0;
                    end else begin
                        pre_cnt <= '0;
                    end
                end
                S_ST1: begin
                    bit_cnt <= '0;
                    state   <= mdio_i ? S_HDR : S_PRE;
                end
                S_HDR: begin
                    hdr_r   <= hdr_nx;
                    bit_cnt <= bit_cnt + 1'b1;
                    if (op_chk && !op_ok) begin
                        state <= S_PRE;
                    end else if (hdr_last) begin
                        if (hit) begin
                            state    <= S_TA1;
                            reg_addr <= hdr_nx[REG_W-1:0];
                            is_rd    <= (hdr_nx[HDR_W-1 -: 2] == OP_RD);
                            chan     <= chan_b_in;
                        end else begin
                            state <= S_PRE;
                        end
                    end
                end
                S_TA1: state <= S_TA2;
                S_TA2: begin
                    state   <= S_DATA;
                    bit_cnt <= '0;
                end
                S_DATA: begin
                    if (data_last) state <= S_PRE;
                    else           bit_cnt <= bit_cnt + 1'b1;
                end
                default: state <= S_PRE;
            endcase
        end
    end

    // R4: start bits are only taken after a saturated preamble count.
    assert_start_needs_preamble_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_ST1) |-> ($past(pre_cnt) == PRE_CW'(PRE_LEN)));

    // R8: a mismatching station address drops the frame.
    assert_nomatch_abandons_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_last && !hit) |=> (state == S_PRE));

    // R5: only legal opcodes reach the turnaround slot.
    assert_legal_opcode_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_TA1) |-> ((hdr_r[HDR_W-1 -: 2] == OP_RD) || (hdr_r[HDR_W-1 -: 2] == OP_WR)));
endmodule

// File: rtl/mdio_data_path.sv
`timescale 1ns/1ps
// Data shifter for the management slave.
// Loads bank read data in the first turnaround slot and shifts it out
// MSB first; for writes, shifts data in and raises one bank strobe.
// Assumes the decoder's state and data_last are registered in clk.
module mdio_data_path
    import mdio_dual_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mdio_i,
    input  frame_state_e      state,
    input  logic              is_rd,
    input  logic              chan,
    input  logic              data_last,
    input  logic [DATA_W-1:0] rdata_a,
    input  logic [DATA_W-1:0] rdata_b,
    output logic              oe_r,
    output logic              o_r,
    output logic              we_a,
    output logic              we_b,
    output logic [DATA_W-1:0] wdata
);
    logic [DATA_W-1:0] sh;
    logic [DATA_W-1:0] sh_in;

    // Next shift value when receiving a write bit.
    always_comb sh_in = {sh[DATA_W-2:0], mdio_i};

    // Drive, shift and strobe generation per data-phase slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oe_r  <= 1'b0;
            o_r   <= 1'b0;
            we_a  <= 1'b0;
            we_b  <= 1'b0;
            sh    <= '0;
            wdata <= '0;
        end else begin
            we_a <= 1'b0;
            we_b <= 1'b0;
            case (state)
                S_TA1: if (is_rd) begin
                    sh   <= chan ? rdata_b : rdata_a;
                    oe_r <= 1'b1;
                    o_r  <= 1'b0;
                end
                S_TA2: if (is_rd) begin
                    o_r <= sh[DATA_W-1];
                    sh  <= sh << 1;
                end
                S_DATA: begin
                    if (is_rd) begin
                        if (data_last) begin
                            oe_r <= 1'b0;
                            o_r  <= 1'b0;
                        end else begin
                            o_r <= sh[DATA_W-1];
                            sh  <= sh << 1;
                        end
                    end else begin
                        sh <= sh_in;
                        if (data_last) begin
                            wdata <= sh_in;
                            we_a  <= !chan;
                            we_b  <= chan;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // R6: the enable rises with a driven zero (second turnaround bit).
    assert_ta2_drives_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oe_r) |-> !o_r);

    // R7: a write strobe lasts exactly one cycle.
    assert_strobe_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (we_a || we_b) |=> !(we_a || we_b));

    // R3: never strobe both banks together.
    assert_strobe_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({we_a, we_b}));
endmodule

// File: rtl/mdio_dual_slave.sv
`timescale 1ns/1ps
// Dual-port management slave top.
// One MDC/MDIO pair serves two register banks at adjacent station
// addresses. Assumes an external pull-up and tri-state pad built from
// mdio_o and mdio_oe; the enable is gated by reset so the line is
// released for the whole reset period.
module mdio_dual_slave
    import mdio_dual_pkg::*;
#(
    parameter int PRE_LEN = 32,
    parameter int PHY_W   = 5,
    parameter int REG_W   = 5,
    parameter int DATA_W  = 16
) (
    input  logic              mdc,
    input  logic              rst_n,
    input  logic              mdio_i,
    output logic              mdio_o,
    output logic              mdio_oe,
    input  logic [PHY_W-1:0]  strap_addr,
    output logic [REG_W-1:0]  reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    input  logic [DATA_W-1:0] chan_a_rdata,
    output logic              chan_a_wr,
    input  logic [DATA_W-1:0] chan_b_rdata,
    output logic              chan_b_wr
);
    frame_state_e     fsm_state;
    logic [PHY_W-1:0] phy_next;
    logic             hit;
    logic             chan_b_sel;
    logic             is_rd;
    logic             chan;
    logic             data_last;
    logic             oe_r;
    logic             o_r;

    mdio_port_match #(.PHY_W(PHY_W)) u_match (
        .phy_addr (phy_next),
        .strap    (strap_addr),
        .hit      (hit),
        .chan_b   (chan_b_sel)
    );

    mdio_frame_fsm #(
        .PRE_LEN (PRE_LEN),
        .PHY_W   (PHY_W),
        .REG_W   (REG_W),
        .DATA_W  (DATA_W)
    ) u_fsm (
        .clk       (mdc),
        .rst_n     (rst_n),
        .mdio_i    (mdio_i),
        .hit       (hit),
        .chan_b_in (chan_b_sel),
        .state     (fsm_state),
        .phy_next  (phy_next),
        .reg_addr  (reg_addr),
        .is_rd     (is_rd),
        .chan      (chan),
        .data_last (data_last)
    );

    mdio_data_path #(.DATA_W(DATA_W)) u_data (
        .clk       (mdc),
        .rst_n     (rst_n),
        .mdio_i    (mdio_i),
        .state     (fsm_state),
        .is_rd     (is_rd),
        .chan      (chan),
        .data_last (data_last),
        .rdata_a   (chan_a_rdata),
        .rdata_b   (chan_b_rdata),
        .oe_r      (oe_r),
        .o_r       (o_r),
        .we_a      (chan_a_wr),
        .we_b      (chan_b_wr),
        .wdata     (reg_wdata)
    );

    // Pad controls: reset releases the line without waiting for an edge.
    always_comb begin
        mdio_oe = oe_r & rst_n;
        mdio_o  = o_r;
    end

    // R1: the driver only turns on from the turnaround slot of a served frame.
    assert_oe_from_turnaround_R1: assert property (@(posedge mdc) disable iff (!rst_n)
        $rose(mdio_oe) |-> ($past(fsm_state) == S_TA1));
endmodule

// File: tb/mdio_dual_slave_test.sv
`timescale 1ns/1ps
// Self-checking bench: a behavioural frame model computes the expected
// pad and strobe values for every MDC cycle and compares them.
module mdio_dual_slave_test;
    logic        mdc = 1'b0;
    logic        rst_n = 1'b0;
    logic        mdio_i = 1'b1;
    logic        mdio_o, mdio_oe;
    logic [4:0]  strap_addr = 5'b10110;
    logic [4:0]  reg_addr;
    logic [15:0] reg_wdata;
    logic [15:0] chan_a_rdata, chan_b_rdata;
    logic        chan_a_wr, chan_b_wr;

    logic [15:0] mem_a [32];
    logic [15:0] mem_b [32];
    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 mdc = ~mdc;   // 250 MHz

    assign chan_a_rdata = mem_a[reg_addr];
    assign chan_b_rdata = mem_b[reg_addr];

    mdio_dual_slave uut (
        .mdc(mdc), .rst_n(rst_n), .mdio_i(mdio_i), .mdio_o(mdio_o),
        .mdio_oe(mdio_oe), .strap_addr(strap_addr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .chan_a_rdata(chan_a_rdata),
        .chan_a_wr(chan_a_wr), .chan_b_rdata(chan_b_rdata),
        .chan_b_wr(chan_b_wr)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // One MDC cycle: drive at the falling edge, compare after the rising edge.
    task automatic step(input logic b, input logic e_oe, input logic e_o,
                        input logic e_wa, input logic e_wb, input string tag);
        logic [3:0] act, exp;
        mdio_i = b;
        @(posedge mdc);
        @(negedge mdc);
        act = {mdio_oe, mdio_oe & mdio_o, chan_a_wr, chan_b_wr};
        exp = {e_oe, e_oe & e_o, e_wa, e_wb};
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: {oe,o,wa,wb} actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic send_hdr(input int pre, input logic [1:0] op, input logic [4:0] phy,
                            input logic [4:0] rg, input string tag);
        for (int i = 0; i < pre; i++) step(1'b1, 0, 0, 0, 0, tag);
        step(1'b0, 0, 0, 0, 0, tag);
        step(1'b1, 0, 0, 0, 0, tag);
        for (int i = 1; i >= 0; i--) step(op[i], 0, 0, 0, 0, tag);
        for (int i = 4; i >= 0; i--) step(phy[i], 0, 0, 0, 0, tag);
        for (int i = 4; i >= 0; i--) step(rg[i], 0, 0, 0, 0, tag);
    endtask

    // Whole frame with expectations derived from the requirements.
    task automatic do_frame(input int pre, input logic [1:0] op, input logic [4:0] phy,
                            input logic [4:0] rg, input logic [15:0] wd, input string tag);
        bit hit, rd, ch, wstb;
        logic [15:0] exp;
        hit = (pre >= 32) && (op == 2'b10 || op == 2'b01) && (phy[4:1] == strap_addr[4:1]);
        rd  = (op == 2'b10);
        ch  = phy[0];
        send_hdr(pre, op, phy, rg, tag);
        if (hit && rd) begin
            exp = ch ? mem_b[rg] : mem_a[rg];
            step(1'b1, 1, 0, 0, 0, tag);            // first turnaround: zero driven after it
            step(1'b1, 1, exp[15], 0, 0, tag);
            for (int i = 0; i < 16; i++) begin
                if (i < 15) step(1'b1, 1, exp[14-i], 0, 0, tag);
                else        step(1'b1, 0, 0, 0, 0, tag);
            end
        end else begin
            step(1'b1, 0, 0, 0, 0, tag);
            step(1'b0, 0, 0, 0, 0, tag);
            for (int i = 0; i < 16; i++) begin
                wstb = hit && !rd && (i == 15);
                step(rd ? 1'b1 : wd[15-i], 0, 0, wstb && !ch, wstb && ch, tag);
                if (wstb) begin
                    chk({tag, " wdata"}, {16'h0, reg_wdata}, {16'h0, wd});
                    chk({tag, " addr"}, {27'h0, reg_addr}, {27'h0, rg});
                    if (ch) mem_b[rg] = wd; else mem_a[rg] = wd;
                end
            end
        end
        step(1'b0, 0, 0, 0, 0, tag);   // strobe gone, preamble count restarts
    endtask

    initial begin
        for (int i = 0; i < 32; i++) begin
            mem_a[i] = 16'h8000 | 16'(i * 3);
            mem_b[i] = 16'h4100 ^ 16'(i << 7);
        end
        repeat (3) @(negedge mdc);
        chk("R9 reset oe", {31'h0, mdio_oe}, 32'h0);
        chk("R9 reset strobes", {30'h0, chan_a_wr, chan_b_wr}, 32'h0);
        rst_n = 1'b1;
        step(1'b0, 0, 0, 0, 0, "R9 idle");

        do_frame(32, 2'b01, 5'b10110, 5'd3, 16'hA5C3, "R7 write A");
        do_frame(32, 2'b01, 5'b10111, 5'd3, 16'h1234, "R3 write B");
        do_frame(32, 2'b10, 5'b10110, 5'd3, 16'h0, "R6 read A");
        do_frame(32, 2'b10, 5'b10111, 5'd3, 16'h0, "R3 read B");
        do_frame(40, 2'b10, 5'b10111, 5'd31, 16'h0, "R6 read B reg31");
        do_frame(32, 2'b01, 5'b10110, 5'd0, 16'h8001, "R7 write A reg0");
        do_frame(32, 2'b10, 5'b10110, 5'd0, 16'h0, "R6 read A reg0");
        // mismatch, then a served frame after a fresh preamble
        do_frame(32, 2'b01, 5'b00111, 5'd3, 16'hFFFF, "R1 mismatch write");
        do_frame(32, 2'b10, 5'b10011, 5'd3, 16'h0, "R8 mismatch read");
        do_frame(32, 2'b10, 5'b10111, 5'd3, 16'h0, "R8 served after mismatch");
        // strap bit 0 flipped
        strap_addr = 5'b10111;
        do_frame(32, 2'b01, 5'b10110, 5'd9, 16'h0F0F, "R2 write strap0");
        do_frame(32, 2'b10, 5'b10110, 5'd9, 16'h0, "R2 read strap0");
        // short preamble and illegal opcodes, then read back untouched words
        do_frame(31, 2'b01, 5'b10110, 5'd9, 16'hDEAD, "R4 short preamble");
        do_frame(32, 2'b11, 5'b10110, 5'd9, 16'hBEEF, "R5 opcode 11");
        do_frame(32, 2'b00, 5'b10111, 5'd3, 16'hBEEF, "R5 opcode 00");
        do_frame(32, 2'b10, 5'b10110, 5'd9, 16'h0, "R4 readback");
        do_frame(32, 2'b10, 5'b10111, 5'd3, 16'h0, "R5 readback");
        // other strap value
        strap_addr = 5'b00001;
        do_frame(32, 2'b01, 5'b00001, 5'd17, 16'h7E81, "R1 strap 0000 write B");
        do_frame(32, 2'b10, 5'b00001, 5'd17, 16'h0, "R1 strap 0000 read B");
        do_frame(32, 2'b10, 5'b00011, 5'd17, 16'h0, "R1 strap 0000 mismatch");
        // reset in the middle of a read
        send_hdr(32, 2'b10, 5'b00000, 5'd3, "R9 hdr");
        step(1'b1, 1, 0, 0, 0, "R9 ta");
        step(1'b1, 1, mem_a[3][15], 0, 0, "R9 first bit");
        rst_n = 1'b0;
        #1;
        chk("R9 oe drops at once", {31'h0, mdio_oe}, 32'h0);
        @(negedge mdc);
        for (int i = 0; i < 3; i++) step(1'b1, 0, 0, 0, 0, "R9 held");
        rst_n = 1'b1;
        step(1'b0, 0, 0, 0, 0, "R9 release");
        do_frame(32, 2'b10, 5'b00000, 5'd3, 16'h0, "R9 read after reset");

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule